// File: doc/BRIEF.md
# Monte Carlo inverse element estimator

This block estimates a single entry b(i,j) of the inverse of a matrix A through random walks over the matrix D = I − A. Three small tables are fixed at elaboration: a per-row table of cumulative transition thresholds, one sign bit per entry of D, and a per-row weight E_r, which is the sum of |d(r,c)| along row r. Preparing these tables and any floating-point conversion are done outside the block.

After a start pulse the block runs 2^L chains of T steps each. Every chain begins at row i with weight 1.0. At each step a 16-bit pseudo-random value picks the next row from the departing row's thresholds. The weight is then multiplied by the departing row's weight and by the sign of the crossed entry of D. Whenever the walk lands on column j, the new weight is added to a running total. When the last chain finishes, the total is divided by the chain count with an arithmetic shift and presented together with a one-cycle done pulse. Weights are signed Q8.16 fixed point and the accumulator is a wider signed value in the same scaling.

Top module: `mcie_estimator`

## Requirements
- R1: A start pulse sampled while idle latches the row, column, step count and chain exponent, clears the accumulator, seeds the generator and begins the walk. A start pulse during a run has no effect on that run's result.
- R2: Every chain begins at the latched row with weight 1.0, which is 0x010000 in Q8.16.
- R3: The generator is 16 bits wide. On each step it shifts left and takes as its new bit 0 the XOR of its bits 15, 13, 12 and 10. It advances once per step before the draw, and each start reloads it with the seed parameter (default 0xACE1).
- R4: The next row is the lowest column c whose 16-bit threshold for the current row is greater than or equal to the fresh generator value. If no threshold qualifies, the last column is taken. The threshold for entry (r,c) sits at bit offset (r·n + c)·16 of the threshold table.
- R5: The new weight equals floor(w·E_r / 2^16), negated when the sign bit of entry (r,c) is 1. The sign bit of (r,c) sits at bit r·n + c, and E_r sits at bit offset r·24 of the weight table.
- R6: A new weight outside the Q8.16 range saturates to 0x7FFFFF or to −0x800000.
- R7: The new weight is added to the accumulator when the drawn column equals the latched column. On any other step the accumulator is unchanged.
- R8: Each chain runs T steps, and T = 0 runs as T = 1. The number of chains is 2^L, where L is the chain exponent.
- R9: The estimate is the accumulator shifted arithmetically right by L (a floor division). It is held until the next run completes.
- R10: done is high for exactly one cycle, after the (2^L·T + 1)-th rising edge following the edge that samples start. The estimate is updated on that same edge.
- R11: After reset, done is low and the estimate is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when the block is idle |
| row_i | input | $clog2(N_ROWS) | Row index i of the wanted entry |
| col_j | input | $clog2(N_ROWS) | Column index j of the wanted entry |
| steps_t | input | T_W | Steps per chain |
| log2_chains | input | LOGN_W | Chain exponent L, with 2^L chains |
| estimate | output | ACC_W | Signed Q.16 estimate of b(i,j) |
| done | output | 1 | One-cycle pulse when the estimate is updated |

## Verification
The bench uses four rows, 24-bit weights, a 40-bit accumulator and the default seed. Its tables are chosen to reach distinct behaviours:
- Row 1 always moves to row 2 across a negative entry, so the first step's result can be predicted exactly.
- Row 3 loops on itself with weight 3.0 nearly every step, which drives the weight into saturation within a few steps.
- Rows 0 and 2 split their transitions evenly or in quarters, which exercises the threshold comparison across several columns.

Chain exponents from 0 to 4 and chain lengths from 0 to 20 cover the divide shift, the zero-length rule and the completion latency.

// File: rtl/mcie_pkg.sv
package mcie_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIN  = 2'd2
   } mcie_state_e;

endpackage

// File: rtl/mcie_lfsr.sv
module mcie_lfsr #(
   parameter int           W        = 16,
   parameter logic [W-1:0] TAP_MASK = 16'hB400,
   parameter logic [W-1:0] SEED     = 16'hACE1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic         adv_i,
   output logic [W-1:0] nxt_o
);

   if (W < 4) begin : g_bad_width
      $error("mcie_lfsr: W must be at least 4");
   end
   if (SEED == '0) begin : g_bad_seed
      $error("mcie_lfsr: an all-zero seed locks the register");
   end
   if (TAP_MASK[W-1] != 1'b1) begin : g_bad_taps
      $error("mcie_lfsr: the top bit must be a tap");
   end

   logic [W-1:0] st_q;
   logic         fb;

   assign fb    = ^(st_q & TAP_MASK);
   assign nxt_o = {st_q[W-2:0], fb};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= SEED;
      end else if (load_i) begin
         st_q <= SEED;
      end else if (adv_i) begin
         st_q <= nxt_o;
      end
   end

endmodule

// File: rtl/mcie_row_draw.sv
module mcie_row_draw #(
   parameter int                            N_ROWS  = 4,
   parameter int                            P_W     = 16,
   parameter int                            IDX_W   = $clog2(N_ROWS),
   parameter logic [N_ROWS*N_ROWS*P_W-1:0] CUM_TAB = '1
) (
   input  logic [IDX_W-1:0] row_i,
   input  logic [P_W-1:0]   u_i,
   output logic [IDX_W-1:0] col_o
);

   localparam int ROW_BITS = N_ROWS * P_W;

   logic [ROW_BITS-1:0] row_thr;
   logic [N_ROWS-1:0]   qual;

   // select the threshold row of the departing state
   always_comb begin
      row_thr = '0;
      for (int r = 0; r < N_ROWS; r++) begin
         if (int'(row_i) == r) begin
            row_thr = CUM_TAB[r*ROW_BITS +: ROW_BITS];
         end
      end
   end

   for (genvar c = 0; c < N_ROWS; c++) begin : g_cmp
      assign qual[c] = (u_i <= row_thr[c*P_W +: P_W]);
   end

   // lowest qualifying column wins; last column if none qualifies
   always_comb begin
      col_o = IDX_W'(N_ROWS - 1);
      for (int c = N_ROWS - 1; c >= 0; c--) begin
         if (qual[c]) begin
            col_o = IDX_W'(c);
         end
      end
   end

endmodule

// File: rtl/mcie_weight_step.sv
module mcie_weight_step #(
   parameter int W_W      = 24,
   parameter int FRAC_W   = 16,
   parameter bit SATURATE = 1'b1
) (
   input  logic [W_W-1:0] w_i,
   input  logic [W_W-1:0] e_i,
   input  logic           neg_i,
   output logic [W_W-1:0] w_o
);

   localparam int PR_W = 2 * W_W + 2;
   localparam logic signed [PR_W-1:0] SAT_HI =
      $signed((PR_W'(1) << (W_W - 1)) - PR_W'(1));
   localparam logic signed [PR_W-1:0] SAT_LO =
      $signed(-(PR_W'(1) << (W_W - 1)));

   if (FRAC_W >= W_W) begin : g_bad_frac
      $error("mcie_weight_step: FRAC_W must be below W_W");
   end

   logic signed [PR_W-1:0] prod;
   logic signed [PR_W-1:0] shr;
   logic signed [PR_W-1:0] sgn;

   assign prod = $signed({{(PR_W-W_W){w_i[W_W-1]}}, w_i})
               * $signed({{(PR_W-W_W){1'b0}}, e_i});
   assign shr  = prod >>> FRAC_W;
   assign sgn  = neg_i ? -shr : shr;

   if (SATURATE) begin : g_sat
      always_comb begin
         if (sgn > SAT_HI) begin
            w_o = SAT_HI[W_W-1:0];
         end else if (sgn < SAT_LO) begin
            w_o = SAT_LO[W_W-1:0];
         end else begin
            w_o = sgn[W_W-1:0];
         end
      end
   end else begin : g_wrap
      assign w_o = sgn[W_W-1:0];
   end

endmodule

// File: rtl/mcie_estimator.sv
module mcie_estimator #(
   parameter int                                N_ROWS    = 4,
   parameter int                                P_W       = 16,
   parameter int                                W_W       = 24,
   parameter int                                FRAC_W    = 16,
   parameter int                                ACC_W     = 40,
   parameter int                                T_W       = 12,
   parameter int                                LOGN_W    = 4,
   parameter bit                                SATURATE  = 1'b1,
   parameter logic [P_W-1:0]                    TAP_MASK  = 16'hB400,
   parameter logic [P_W-1:0]                    LFSR_SEED = 16'hACE1,
   parameter logic [N_ROWS*N_ROWS*P_W-1:0]      CUM_TAB   = {
      16'hFFFF, 16'h1000, 16'h1000, 16'h1000,
      16'hFFFF, 16'h8000, 16'h8000, 16'h8000,
      16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000,
      16'hFFFF, 16'hC000, 16'h8000, 16'h4000},
   parameter logic [N_ROWS*N_ROWS-1:0]          SIGN_TAB  = 16'h1842,
   parameter logic [N_ROWS*W_W-1:0]             ROW_E     = {
      24'h030000, 24'h008000, 24'h018000, 24'h00C000}
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       start,
   input  logic [$clog2(N_ROWS)-1:0]  row_i,
   input  logic [$clog2(N_ROWS)-1:0]  col_j,
   input  logic [T_W-1:0]             steps_t,
   input  logic [LOGN_W-1:0]          log2_chains,
   output logic [ACC_W-1:0]           estimate,
   output logic                       done
);

   import mcie_pkg::*;

   localparam int             IDX_W = $clog2(N_ROWS);
   localparam int             CH_W  = 1 << LOGN_W;
   localparam logic [W_W-1:0] ONE   = W_W'(1) << FRAC_W;

   if (N_ROWS < 2) begin : g_bad_rows
      $error("mcie_estimator: N_ROWS must be at least 2");
   end
   if (ACC_W <= W_W) begin : g_bad_acc
      $error("mcie_estimator: ACC_W must exceed W_W");
   end
   if (LOGN_W < 1 || LOGN_W > 5) begin : g_bad_logn
      $error("mcie_estimator: LOGN_W must lie in 1..5");
   end
   if (T_W < 1) begin : g_bad_tw
      $error("mcie_estimator: T_W must be positive");
   end

   mcie_state_e        state_q;
   logic [IDX_W-1:0]   tgt_row_q;
   logic [IDX_W-1:0]   tgt_col_q;
   logic [T_W-1:0]     t_last_q;
   logic [CH_W-1:0]    n_last_q;
   logic [LOGN_W-1:0]  log_n_q;
   logic [IDX_W-1:0]   cur_row_q;
   logic [W_W-1:0]     weight_q;
   logic [T_W-1:0]     step_cnt_q;
   logic [CH_W-1:0]    chain_cnt_q;
   logic signed [ACC_W-1:0] acc_q;

   logic               accept;
   logic               stepping;
   logic [P_W-1:0]     rnd;
   logic [IDX_W-1:0]   draw_col;
   logic [W_W-1:0]     e_row;
   logic               neg_sel;
   logic [W_W-1:0]     w_new;
   logic               hit;
   logic               chain_end;
   logic               run_end;

   assign accept   = start && (state_q == ST_IDLE);
   assign stepping = (state_q == ST_RUN);

   mcie_lfsr #(
      .W        (P_W),
      .TAP_MASK (TAP_MASK),
      .SEED     (LFSR_SEED)
   ) u_lfsr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .adv_i  (stepping),
      .nxt_o  (rnd)
   );

   mcie_row_draw #(
      .N_ROWS  (N_ROWS),
      .P_W     (P_W),
      .IDX_W   (IDX_W),
      .CUM_TAB (CUM_TAB)
   ) u_draw (
      .row_i (cur_row_q),
      .u_i   (rnd),
      .col_o (draw_col)
   );

   assign e_row   = ROW_E[int'(cur_row_q)*W_W +: W_W];
   assign neg_sel = SIGN_TAB[int'(cur_row_q)*N_ROWS + int'(draw_col)];

   mcie_weight_step #(
      .W_W      (W_W),
      .FRAC_W   (FRAC_W),
      .SATURATE (SATURATE)
   ) u_wstep (
      .w_i   (weight_q),
      .e_i   (e_row),
      .neg_i (neg_sel),
      .w_o   (w_new)
   );

   assign hit       = (draw_col == tgt_col_q);
   assign chain_end = (step_cnt_q == t_last_q);
   assign run_end   = chain_end && (chain_cnt_q == n_last_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         tgt_row_q   <= '0;
         tgt_col_q   <= '0;
         t_last_q    <= '0;
         n_last_q    <= '0;
         log_n_q     <= '0;
         cur_row_q   <= '0;
         weight_q    <= '0;
         step_cnt_q  <= '0;
         chain_cnt_q <= '0;
         acc_q       <= '0;
         estimate    <= '0;
         done        <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (start) begin
                  tgt_row_q   <= row_i;
                  tgt_col_q   <= col_j;
                  t_last_q    <= (steps_t == '0) ? '0 : steps_t - T_W'(1);
                  n_last_q    <= ~({CH_W{1'b1}} << log2_chains);
                  log_n_q     <= log2_chains;
                  cur_row_q   <= row_i;
                  weight_q    <= ONE;
                  step_cnt_q  <= '0;
                  chain_cnt_q <= '0;
                  acc_q       <= '0;
                  state_q     <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (hit) begin
                  acc_q <= acc_q + $signed({{(ACC_W-W_W){w_new[W_W-1]}}, w_new});
               end
               if (chain_end) begin
                  step_cnt_q <= '0;
                  cur_row_q  <= tgt_row_q;
                  weight_q   <= ONE;
                  if (run_end) begin
                     state_q <= ST_FIN;
                  end else begin
                     chain_cnt_q <= chain_cnt_q + CH_W'(1);
                  end
               end else begin
                  step_cnt_q <= step_cnt_q + T_W'(1);
                  cur_row_q  <= draw_col;
                  weight_q   <= w_new;
               end
            end
            ST_FIN: begin
               estimate <= acc_q >>> log_n_q;
               done     <= 1'b1;
               state_q  <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/mcie_estimator_chk.sv
module mcie_estimator_chk #(
   parameter int W_W    = 24,
   parameter int FRAC_W = 16,
   parameter int ACC_W  = 40,
   parameter int T_W    = 12
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    start,
   input logic                    done,
   input logic [ACC_W-1:0]        estimate,
   input mcie_pkg::mcie_state_e   state_q,
   input logic [T_W-1:0]          step_cnt_q,
   input logic [W_W-1:0]          weight_q,
   input logic [ACC_W-1:0]        acc_q,
   input logic                    hit
);

   import mcie_pkg::*;

   localparam logic [W_W-1:0] ONE = W_W'(1) << FRAC_W;

   assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_est_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(estimate) |-> done);

   assert_acc_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (start && state_q == ST_IDLE) |=> (acc_q == '0));

   assert_chain_init_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && step_cnt_q == '0) |-> (weight_q == ONE));

   assert_miss_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_RUN && !hit) |=> $stable(acc_q));

endmodule

bind mcie_estimator mcie_estimator_chk #(
   .W_W    (W_W),
   .FRAC_W (FRAC_W),
   .ACC_W  (ACC_W),
   .T_W    (T_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start      (start),
   .done       (done),
   .estimate   (estimate),
   .state_q    (state_q),
   .step_cnt_q (step_cnt_q),
   .weight_q   (weight_q),
   .acc_q      (acc_q),
   .hit        (hit)
);

// File: tb/mcie_estimator_tb.sv
module mcie_estimator_tb;

   localparam logic [255:0] CUM_TB = {
      16'hFFFF, 16'h1000, 16'h1000, 16'h1000,
      16'hFFFF, 16'h8000, 16'h8000, 16'h8000,
      16'hFFFF, 16'hFFFF, 16'h0000, 16'h0000,
      16'hFFFF, 16'hC000, 16'h8000, 16'h4000};
   localparam logic [15:0]  SIGN_TB = 16'h1842;
   localparam logic [95:0]  E_TB    = {24'h030000, 24'h008000, 24'h018000, 24'h00C000};
   localparam logic [15:0]  SEED_TB = 16'hACE1;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [1:0]  row_i = '0;
   logic [1:0]  col_j = '0;
   logic [11:0] steps_t = '0;
   logic [3:0]  log2_chains = '0;
   logic [39:0] estimate;
   logic        done;

   int total = 0;
   int bad = 0;

   always #2 clk = ~clk;

   mcie_estimator #(
      .N_ROWS (4), .P_W (16), .W_W (24), .FRAC_W (16), .ACC_W (40),
      .T_W (12), .LOGN_W (4), .SATURATE (1'b1), .TAP_MASK (16'hB400),
      .LFSR_SEED (SEED_TB), .CUM_TAB (CUM_TB), .SIGN_TAB (SIGN_TB), .ROW_E (E_TB)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .start (start), .row_i (row_i), .col_j (col_j),
      .steps_t (steps_t), .log2_chains (log2_chains),
      .estimate (estimate), .done (done)
   );

   task automatic chk(input bit ok, input string req, input longint got, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   // estimate computed from the requirement text
   function automatic longint model(input int i, input int j, input int t, input int logn);
      logic [15:0] s = SEED_TB;
      longint acc = 0;
      longint w;
      longint p;
      longint e;
      int row;
      int c;
      int nt = (t == 0) ? 1 : t;
      for (int ch = 0; ch < (1 << logn); ch++) begin
         row = i;
         w = 65536;
         for (int st = 0; st < nt; st++) begin
            s = {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
            c = 3;
            for (int cc = 3; cc >= 0; cc--) begin
               if (s <= CUM_TB[(row*4+cc)*16 +: 16]) c = cc;
            end
            e = longint'(E_TB[row*24 +: 24]);
            p = (w * e) >>> 16;
            if (SIGN_TB[row*4+c]) p = -p;
            if (p > 64'sh7FFFFF) p = 64'sh7FFFFF;
            if (p < -64'sh800000) p = -64'sh800000;
            if (c == j) acc += p;
            row = c;
            w = p;
         end
      end
      return acc >>> logn;
   endfunction

   task automatic launch(input int i, input int j, input int t, input int logn);
      @(negedge clk);
      row_i = 2'(i); col_j = 2'(j); steps_t = 12'(t); log2_chains = 4'(logn);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_done(output bit seen);
      seen = 1'b0;
      for (int k = 0; k < 100000; k++) begin
         if (done) begin
            seen = 1'b1;
            break;
         end
         @(negedge clk);
      end
   endtask

   task automatic run_case(input int i, input int j, input int t, input int logn,
                           input longint exp, input string req);
      bit seen;
      longint got;
      launch(i, j, t, logn);
      wait_done(seen);
      got = longint'($signed(estimate));
      chk(seen && got == exp, req, got, exp);
      @(negedge clk);
      chk(!done, "R10 done one cycle", longint'(done), 0);
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(!done, "R11 done after reset", longint'(done), 0);
      chk(estimate == '0, "R11 estimate after reset", longint'($signed(estimate)), 0);
   endtask

   task automatic t_exact;
      // row 1 always moves to row 2 across a negative entry, E1 = 1.5
      run_case(1, 2, 1, 0, -98304, "R5 signed step R7 hit");
      run_case(1, 2, 0, 0, -98304, "R8 zero length");
   endtask

   task automatic t_walks;
      run_case(0, 0, 8, 2, model(0, 0, 8, 2), "R2/R3/R4 walk");
      run_case(3, 3, 16, 1, model(3, 3, 16, 1), "R6 saturation walk");
      run_case(2, 0, 20, 4, model(2, 0, 20, 4), "R9 shift by four");
      run_case(0, 3, 5, 3, model(0, 3, 5, 3), "R7 accumulate R8 chains");
   endtask

   task automatic t_latency;
      int cnt = 0;
      @(negedge clk);
      row_i = 2'd0; col_j = 2'd1; steps_t = 12'd3; log2_chains = 4'd1;
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 1000; k++) begin
         @(posedge clk);
         cnt++;
         @(negedge clk);
         if (done) break;
      end
      chk(cnt == 7, "R10 latency", cnt, 7);
   endtask

   task automatic t_busy;
      bit seen;
      longint got;
      longint exp = model(2, 0, 20, 2);
      launch(2, 0, 20, 2);
      repeat (10) @(negedge clk);
      row_i = 2'd0; col_j = 2'd3; steps_t = 12'd1; log2_chains = 4'd0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      wait_done(seen);
      got = longint'($signed(estimate));
      chk(seen && got == exp, "R1 start ignored while busy", got, exp);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_exact();
      t_walks();
      t_latency();
      t_busy();
      repeat (2) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule